// File: doc/BRIEF.md
# Glitch-Free Power-of-Two Clock Divider

This block derives an output clock from a master clock at the master rate divided by 2^N. N is an unsigned value from 0 to 7 taken from a 3-bit select, so the ratios run from 1 to 128. With N = 0 the master clock itself is passed to the output through a gate. After reset is released, a fixed start-up interval has to run out before the output may toggle. Until then it stays low.

The select is asynchronous to the master clock and passes through a two-stage synchronizer. The divider can be reprogrammed while it runs. A new ratio is adopted only where the output falls at the end of a complete period of the ratio in force. The divide counter is then cleared, so the new ratio begins with a full low half-period. The full-rate path is enabled and disabled on the falling master edge. It therefore never passes a partial master pulse. No high or low phase is ever shorter than half a master period times the smaller of the old and new ratios.

Top module: `pow2_clk_div`

## Requirements
- R1: For a settled select value N from 1 to 7, the output period is 2^N master cycles, with high and low phases of exactly 2^(N-1) master cycles each.
- R2: For a settled select value N = 0, the output equals the master clock: high for half a master period and low for half a master period.
- R3: While the active-low reset is asserted, the output is 0, and asserting reset forces it to 0 without waiting for a clock edge.
- R4: After reset is released, the output stays 0 for at least STARTUP_CYC (default 16) master cycles, and afterwards begins toggling at the selected ratio.
- R5: When the select moves between two values N and M that are both 1 or more, every phase before the switch has the old half-period length. The first phase of a different length is a low phase of exactly 2^(M-1) master cycles.
- R6: Across any select change, including those to and from N = 0, no output high or low phase is shorter than half a master period times min(2^old, 2^new).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mst | input | 1 | Master clock |
| rst_mst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | SEL_W (3) | Asynchronous exponent N; the ratio is 2^N |
| clk_out | output | 1 | Divided clock output |

## Verification
Each of the 64 ordered pairs of select values is exercised. The bench settles on the first value and then switches to the second. The settled half-periods tell the tap bit of each ratio apart, and the full-rate gate apart from the counter path. Where both values are 1 or more, the first phase that departs from the old length shows whether the switch landed on a period boundary with a clean new low phase. A run of random select changes follows, with every edge timed against the smaller-ratio floor. A reset asserted while the full-rate path is active, followed by a fresh start-up window, tells the asynchronous clear apart from the start-up hold.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
   // Divide counter width: bit k-1 yields ratio 2^k, so 2^SEL_W - 1 bits.
   function automatic int cnt_width(input int sel_w);
      return (1 << sel_w) - 1;
   endfunction
endpackage

// File: rtl/cdiv_sel_sync.sv
`timescale 1ns/1ps
module cdiv_sel_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] d_sync
);
   logic [STAGES-1:0][W-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cdiv_sel_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cdiv_startup.sv
`timescale 1ns/1ps
module cdiv_startup #(
   parameter int CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic live
);
   localparam int CW = $clog2(CYC + 1);
   logic [CW-1:0] tick_q;
   logic          live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= '0;
         live_q <= 1'b0;
      end else if (!live_q) begin
         if (tick_q == CW'(CYC - 1)) live_q <= 1'b1;
         else                        tick_q <= tick_q + 1'b1;
      end
   end

   assign live = live_q;

   AST_LIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |=> live_q); // R4
endmodule

// File: rtl/cdiv_seq.sv
`timescale 1ns/1ps
module cdiv_seq #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             live,
   input  logic [SEL_W-1:0] sel_s,
   output logic             div_q,
   output logic             full_req
);
   localparam int CNT_W = clkdiv_pkg::cnt_width(SEL_W);

   logic [CNT_W-1:0] cnt_q, cnt_inc, low_mask, tap_mask;
   logic [SEL_W-1:0] cur_k_q;
   logic             running_q, full_req_q, div_r;
   logic             at_bound, commit, div_nxt;

   // Masks selected by the active exponent: low bits that close a period,
   // and the single tap bit that forms the divided output.
   generate
      for (genvar i = 0; i < CNT_W; i++) begin : g_mask
         assign low_mask[i] = (int'(cur_k_q) > i);
         assign tap_mask[i] = (int'(cur_k_q) == i + 1);
      end
   endgenerate

   assign cnt_inc  = cnt_q + 1'b1;
   assign at_bound = ((cnt_q & low_mask) == low_mask);
   assign div_nxt  = |(cnt_inc & tap_mask);
   assign commit   = running_q ? ((sel_s != cur_k_q) && at_bound) : live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         cur_k_q    <= '0;
         running_q  <= 1'b0;
         div_r      <= 1'b0;
         full_req_q <= 1'b0;
      end else if (commit) begin
         cnt_q      <= '0;
         cur_k_q    <= sel_s;
         running_q  <= 1'b1;
         div_r      <= 1'b0;
         full_req_q <= (sel_s == '0);
      end else if (running_q) begin
         cnt_q      <= cnt_inc;
         div_r      <= div_nxt;
         full_req_q <= (cur_k_q == '0);
      end
   end

   assign div_q    = div_r;
   assign full_req = full_req_q;

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !running_q |-> (!div_r && !full_req_q)); // R4
   AST_NO_DIV_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && cur_k_q == '0) |-> !div_r); // R2
   AST_SWITCH_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && $past(running_q) && cur_k_q != $past(cur_k_q)) |-> !div_r); // R5
   AST_HALVE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && $past(running_q) && cur_k_q == 1 && $past(cur_k_q) == 1)
      |-> (div_r != $past(div_r))); // R1
endmodule

// File: rtl/cdiv_out_gate.sv
`timescale 1ns/1ps
module cdiv_out_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic full_req,
   input  logic div_q,
   output logic clk_out
);
   logic en_full_q;

   // Enable of the full-rate path changes only while the master clock is low.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en_full_q <= 1'b0;
      else        en_full_q <= full_req;
   end

   assign clk_out = (clk & en_full_q) | div_q;

   AST_PATHS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      en_full_q |-> !div_q); // R6
endmodule

// File: rtl/pow2_clk_div.sv
`timescale 1ns/1ps
module pow2_clk_div #(
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter int STARTUP_CYC = 16
) (
   input  logic             clk_mst,
   input  logic             rst_mst_n,
   input  logic [SEL_W-1:0] div_sel,
   output logic             clk_out
);
   logic [SEL_W-1:0] sel_s;
   logic             live, div_q, full_req;

   generate
      if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel_w
         $error("pow2_clk_div: SEL_W must lie in 1..5");
      end
      if (STARTUP_CYC < 1) begin : g_bad_startup
         $error("pow2_clk_div: STARTUP_CYC must be at least 1");
      end
   endgenerate

   cdiv_sel_sync #(.W(SEL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk_mst), .rst_n(rst_mst_n), .d_async(div_sel), .d_sync(sel_s));

   cdiv_startup #(.CYC(STARTUP_CYC)) u_start (
      .clk(clk_mst), .rst_n(rst_mst_n), .live(live));

   cdiv_seq #(.SEL_W(SEL_W)) u_seq (
      .clk(clk_mst), .rst_n(rst_mst_n), .live(live), .sel_s(sel_s),
      .div_q(div_q), .full_req(full_req));

   cdiv_out_gate u_gate (
      .clk(clk_mst), .rst_n(rst_mst_n), .full_req(full_req),
      .div_q(div_q), .clk_out(clk_out));
endmodule

// File: tb/pow2_clk_div_bench.sv
`timescale 1ns/1ps
module pow2_clk_div_bench;
   logic       clk_mst = 1'b0;
   logic       rst_mst_n = 1'b0;
   logic [2:0] div_sel = 3'd0;
   logic       clk_out;

   int  vec = 0;
   int  bad = 0;
   int  cur_n = 0;
   bit  mon_en = 1'b0;
   bit  have_edge = 1'b0;
   real t_last = 0.0;
   real min_ph = 5.0;

   pow2_clk_div u_pow2_clk_div (
      .clk_mst(clk_mst), .rst_mst_n(rst_mst_n),
      .div_sel(div_sel), .clk_out(clk_out));

   always #5 clk_mst = ~clk_mst;

   function automatic real half_ns(input int n);
      return 5.0 * real'(1 << n);
   endfunction

   function automatic real absr(input real x);
      return (x < 0.0) ? -x : x;
   endfunction

   function automatic int min_i(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   // R6: every phase is timed against the floor of the current transition.
   always @(posedge clk_out or negedge clk_out) begin
      real t;
      t = $realtime;
      if (mon_en && have_edge) begin
         vec++;
         if (t - t_last < min_ph - 0.01) begin
            bad++;
            $display("FAIL R6: phase %0.2f ns, expected >= %0.2f ns at %0t",
                     t - t_last, min_ph, $time);
         end
      end
      t_last = t;
      have_edge = 1'b1;
   end

   task automatic check_bit(input string req, input logic got, input logic exp);
      vec++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: clk_out %b, expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic check_len(input string req, input string what,
                            input real got, input real exp);
      vec++;
      if (absr(got - exp) > 0.01) begin
         bad++;
         $display("FAIL %s: %s %0.2f ns, expected %0.2f ns at %0t",
                  req, what, got, exp, $time);
      end
   endtask

   task automatic set_sel(input int n);
      @(posedge clk_mst);
      #1 div_sel = 3'(n);
   endtask

   task automatic go_to(input int n);
      min_ph = 5.0 * real'(1 << min_i(cur_n, n));
      set_sel(n);
      repeat (300) @(posedge clk_mst);
      cur_n = n;
   endtask

   task automatic measure_settled(input int n);
      real t0, t1, t2;
      @(posedge clk_out); t0 = $realtime;
      @(negedge clk_out); t1 = $realtime;
      @(posedge clk_out); t2 = $realtime;
      if (n == 0) begin
         check_len("R2", "high phase", t1 - t0, 5.0);
         check_len("R2", "low phase",  t2 - t1, 5.0);
      end else begin
         check_len("R1", "high phase", t1 - t0, half_ns(n));
         check_len("R1", "low phase",  t2 - t1, half_ns(n));
      end
   endtask

   // R5: old-length phases until the switch, then a low phase of the new half.
   task automatic switch_watch(input int o, input int n);
      real tp, tn, oh, nh;
      bit  done;
      oh = half_ns(o);
      nh = half_ns(n);
      min_ph = 5.0 * real'(1 << min_i(o, n));
      @(posedge clk_out);
      #1 div_sel = 3'(n);
      tp = $realtime - 1.0;
      done = 1'b0;
      for (int g = 0; g < 600 && !done; g++) begin
         @(posedge clk_out or negedge clk_out);
         tn = $realtime;
         if (absr((tn - tp) - oh) > 0.01) begin
            done = 1'b1;
            vec++;
            if (!(clk_out === 1'b1 && absr((tn - tp) - nh) < 0.01)) begin
               bad++;
               $display("FAIL R5: first new phase %0.2f ns ending in %b, expected low of %0.2f ns (%0d->%0d)",
                        tn - tp, clk_out, nh, o, n);
            end
         end
         tp = tn;
      end
      if (!done) begin
         vec++; bad++;
         $display("FAIL R5: no switch seen, got old %0.2f ns, expected new %0.2f ns (%0d->%0d)",
                  oh, nh, o, n);
      end
      cur_n = n;
      repeat (300) @(posedge clk_mst);
   endtask

   task automatic startup_window(input int n);
      bit rose;
      div_sel = 3'(n);
      cur_n = n;
      @(posedge clk_mst);
      #2 rst_mst_n = 1'b1;
      for (int i = 0; i < 16; i++) begin
         @(posedge clk_mst);
         #2 check_bit("R4", clk_out, 1'b0);
         #5 check_bit("R4", clk_out, 1'b0);
      end
      rose = 1'b0;
      for (int i = 0; i < 200 && !rose; i++) begin
         @(posedge clk_mst);
         #1 if (clk_out === 1'b1) rose = 1'b1;
      end
      check_bit("R4", rose, 1'b1);
      have_edge = 1'b0;
      min_ph = 5.0 * real'(1 << n);
      mon_en = 1'b1;
   endtask

   initial begin
      repeat (195000) @(posedge clk_mst);
      bad++;
      $display("FAIL watchdog: 195000 cycles elapsed, expected completion earlier");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      // R3: output low while reset is held, clock running.
      for (int i = 0; i < 4; i++) begin
         @(posedge clk_mst);
         #2 check_bit("R3", clk_out, 1'b0);
         #5 check_bit("R3", clk_out, 1'b0);
      end
      startup_window(3);
      repeat (100) @(posedge clk_mst);
      measure_settled(3);

      // Exhaustive ordered pairs of select values.
      for (int o = 0; o < 8; o++) begin
         for (int n = 0; n < 8; n++) begin
            go_to(o);
            if (o == n) begin
               measure_settled(n);
            end else if (o >= 1 && n >= 1) begin
               switch_watch(o, n);
               measure_settled(n);
            end else begin
               go_to(n);
               measure_settled(n);
            end
         end
      end

      // R6: random select changes at random offsets.
      for (int k = 0; k < 30; k++) begin
         int nn;
         nn = int'($urandom_range(7, 0));
         min_ph = 5.0 * real'(1 << min_i(cur_n, nn));
         repeat (int'($urandom_range(20, 0))) @(posedge clk_mst);
         #3 div_sel = 3'(nn);
         repeat (300) @(posedge clk_mst);
         cur_n = nn;
         measure_settled(nn);
      end

      // R3: asynchronous clear while the full-rate path is active.
      go_to(0);
      mon_en = 1'b0;
      @(posedge clk_mst);
      #2 rst_mst_n = 1'b0;
      #1 check_bit("R3", clk_out, 1'b0);
      #5 check_bit("R3", clk_out, 1'b0);
      @(posedge clk_mst);
      #2 check_bit("R3", clk_out, 1'b0);
      startup_window(0);
      repeat (50) @(posedge clk_mst);
      measure_settled(0);

      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end
endmodule